// File: doc/BRIEF.md
# Sequential Index Pattern Writer

This block fills a region of external memory with a counting pattern through the write half of an AXI4 memory-mapped master port. Each run writes a fixed number of 32-bit words. Word k holds the value k and sits at the base address plus four times k. The run is cut into incrementing bursts that are never longer than a set beat count and never cross a 4 KB page. It ends once every burst's write response has returned.

Runs are controlled by a start/ready/done/idle handshake. The caller raises start and keeps it high until ready is seen. Ready marks the cycle in which the run is taken. If start is still high when a run ends, the next run is taken straight away.

A build parameter chooses where the base address comes from. It can be a fixed zero, a dedicated input port that is sampled when a run is taken, or a 32-bit register written over a small AXI4-Lite slave port. Any write response other than OKAY sets a sticky error flag.

Top module: `pattern_writer`

## Requirements
- R1: While reset is asserted and after its release, idle is 1 and done, ready, AWVALID and WVALID are 0 until a run is taken.
- R2: ready is 1 exactly when start is 1 and no run is active. A run is taken on that clock edge, and idle reads 0 in the following cycle.
- R3: Word k of a run is written with data k at byte address base + 4*k. WSTRB is 4'b1111, AWSIZE is 3'b010 (4 bytes) and AWBURST is 2'b01 (incrementing).
- R4: Each burst carries at most MAX_BURST beats (AWLEN <= MAX_BURST-1) and never crosses a 4096-byte boundary. WLAST marks its final beat.
- R5: With BASE_SRC = 0 the base is 0x00000000 and the direct input is ignored.
- R6: With BASE_SRC = 1 the base is the direct input (low two bits forced to 0), sampled on the edge that takes the run. Later changes have no effect until the next run is taken.
- R7: With BASE_SRC = 2 the base is held in a 32-bit register written through the AXI4-Lite slave port. Write strobes apply per byte and the register reads back unchanged. The port has no address lines, so the register answers every access.
- R8: done is a single-cycle pulse. It appears in the first idle cycle after the last write response of a run. idle is 0 from the cycle after a run is taken until that pulse.
- R9: If start is still 1 when done pulses, ready is 1 in that same cycle and a new run is taken at the next edge.
- R10: A write response with BRESP not equal to 2'b00 sets err, which stays 1 until the edge that takes the next run, where it clears.
- R11: Once raised, AWVALID and WVALID stay high with stable address, length, data and last flag until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, held until ready |
| ready | output | 1 | Run taken this cycle |
| idle | output | 1 | No run active |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky error-response flag |
| base_in | input | ADDR_W | Direct base address (BASE_SRC = 1) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code, fixed 4 bytes |
| m_awburst | output | 2 | Burst type, fixed incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data (word index) |
| m_wstrb | output | 4 | Byte strobes, all set |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready, high during a run |
| m_bresp | input | 2 | Write response code |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Register byte strobes |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_bresp | output | 2 | Register write response, always OKAY |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response, always OKAY |

## Verification
The assertions assume a well-behaved memory slave. It sends a write response only for a burst whose address has already been accepted. It holds BVALID until BREADY is seen. The in-bench memory model keeps to this by queueing each accepted burst and answering it only after that burst's last data beat. The stimulus holds start until ready is sampled and writes the offset register only while the writer is idle. The base values it uses sit just below a 4 KB page, which forces a split burst, and at page-aligned addresses.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [2:0] SIZE_WORD  = 3'b010;
  localparam logic [1:0] BURST_INCR = 2'b01;

  // beats for the next burst: limited by words left, burst cap and page room
  function automatic int burst_beats(input logic [11:0] page_off,
                                     input int left, input int cap);
    int room;
    int n;
    room = (4096 - int'(page_off)) / 4;
    n = cap;
    if (left < n) n = left;
    if (room < n) n = room;
    return n;
  endfunction
endpackage

// File: rtl/pw_lite_reg.sv
`timescale 1ns/1ps
module pw_lite_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        awvalid,
  output logic        awready,
  input  logic        wvalid,
  output logic        wready,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic        bvalid,
  input  logic        bready,
  output logic [1:0]  bresp,
  input  logic        arvalid,
  output logic        arready,
  output logic        rvalid,
  input  logic        rready,
  output logic [31:0] rdata,
  output logic [1:0]  rresp,
  output logic [31:0] value
);
  import pw_pkg::*;

  logic [31:0] val_q, val_d, rdata_q, rdata_d;
  logic        bv_q, bv_d, rv_q, rv_d;
  logic        wr_go, rd_go;

  assign wr_go   = awvalid && wvalid && !bv_q;
  assign rd_go   = arvalid && !rv_q;
  assign awready = wr_go;
  assign wready  = wr_go;
  assign arready = !rv_q;

  always_comb begin
    val_d   = val_q;
    rdata_d = rdata_q;
    bv_d    = bv_q && !bready;
    rv_d    = rv_q && !rready;
    if (wr_go) begin
      for (int b = 0; b < 4; b++)
        if (wstrb[b]) val_d[8*b +: 8] = wdata[8*b +: 8];
      bv_d = 1'b1;
    end
    if (rd_go) begin
      rdata_d = val_q;
      rv_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      rdata_q <= '0;
      bv_q    <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      val_q   <= val_d;
      rdata_q <= rdata_d;
      bv_q    <= bv_d;
      rv_q    <= rv_d;
    end
  end

  assign bvalid = bv_q;
  assign rvalid = rv_q;
  assign rdata  = rdata_q;
  assign bresp  = RESP_OKAY;
  assign rresp  = RESP_OKAY;
  assign value  = val_q;

  // R7
  lite_resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R7
  lite_reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(awvalid && wvalid && awready) |=> $stable(value));
endmodule

// File: rtl/pw_burst_seq.sv
`timescale 1ns/1ps
module pw_burst_seq #(
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 256,
  parameter int MAX_BURST = 16,
  localparam int CNT_W    = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic              wvalid,
  input  logic              wready,
  output logic [31:0]       wdata,
  output logic              wlast,
  output logic              busy
);
  import pw_pkg::*;

  typedef enum logic [1:0] {SQ_IDLE, SQ_AW, SQ_W} sq_e;

  sq_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [7:0]        beat_q, beat_d, len_q, len_d;
  int                beats;

  always_comb begin
    beats = burst_beats(addr_q[11:0], NUM_WORDS - int'(idx_q), MAX_BURST);
    awlen = 8'(beats - 1);
  end

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    idx_d  = idx_q;
    beat_d = beat_q;
    len_d  = len_q;
    case (st_q)
      SQ_IDLE: if (launch) begin
        addr_d = {base[ADDR_W-1:2], 2'b00};
        idx_d  = '0;
        st_d   = SQ_AW;
      end
      SQ_AW: if (awready) begin
        len_d  = awlen;
        beat_d = '0;
        st_d   = SQ_W;
      end
      SQ_W: if (wready) begin
        idx_d  = idx_q + CNT_W'(1);
        addr_d = addr_q + ADDR_W'(4);
        beat_d = beat_q + 8'd1;
        if (beat_q == len_q)
          st_d = (int'(idx_q) + 1 >= NUM_WORDS) ? SQ_IDLE : SQ_AW;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      beat_q <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
      beat_q <= beat_d;
      len_q  <= len_d;
    end
  end

  assign awvalid = (st_q == SQ_AW);
  assign wvalid  = (st_q == SQ_W);
  assign awaddr  = addr_q;
  assign wdata   = 32'(idx_q);
  assign wlast   = wvalid && (beat_q == len_q);
  assign busy    = (st_q != SQ_IDLE);

  // R11
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  // R11
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
  // R4
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> int'(awlen) < MAX_BURST);
  // R4
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> int'(awaddr[11:0]) + (int'(awlen) + 1) * 4 <= 4096);
endmodule

// File: rtl/pw_resp_track.sv
`timescale 1ns/1ps
module pw_resp_track #(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       aw_fire,
  input  logic       b_fire,
  input  logic [1:0] bresp,
  output logic       drained,
  output logic       err
);
  import pw_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    if (aw_fire && !b_fire)      cnt_d = cnt_q + CNT_W'(1);
    else if (b_fire && !aw_fire) cnt_d = cnt_q - CNT_W'(1);
    err_d = err_q;
    if (clear)                              err_d = 1'b0;
    else if (b_fire && bresp != RESP_OKAY)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign drained = (cnt_q == '0);
  assign err     = err_q;

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |-> !drained);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clear |=> err);
endmodule

// File: rtl/pattern_writer.sv
`timescale 1ns/1ps
module pattern_writer #(
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 256,
  parameter int MAX_BURST = 16,
  parameter int BASE_SRC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic              idle,
  output logic              done,
  output logic              err,
  input  logic [ADDR_W-1:0] base_in,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp
);
  import pw_pkg::*;

  localparam int CNT_W = $clog2(NUM_WORDS + 1);

  typedef enum logic {T_IDLE, T_RUN} top_e;

  top_e              st_q, st_d;
  logic              done_q, done_d;
  logic              accept, finish, seq_busy, drained;
  logic [ADDR_W-1:0] base_sel;

  generate
    if (BASE_SRC == 0) begin : g_zero
      logic unused_in;
      assign unused_in = ^{base_in, s_awvalid, s_wvalid, s_wdata, s_wstrb,
                           s_bready, s_arvalid, s_rready};
      assign base_sel  = '0;
    end else if (BASE_SRC == 1) begin : g_port
      logic unused_in;
      assign unused_in = ^{s_awvalid, s_wvalid, s_wdata, s_wstrb,
                           s_bready, s_arvalid, s_rready};
      assign base_sel  = base_in;
    end else begin : g_reg
      logic        unused_in;
      logic [31:0] reg_val;
      assign unused_in = ^{base_in, reg_val};
      pw_lite_reg u_reg (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .arvalid(s_arvalid), .arready(s_arready),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
        .value(reg_val)
      );
      assign base_sel = ADDR_W'(reg_val);
    end
    if (BASE_SRC != 2) begin : g_no_reg
      assign s_awready = 1'b0;
      assign s_wready  = 1'b0;
      assign s_bvalid  = 1'b0;
      assign s_bresp   = RESP_OKAY;
      assign s_arready = 1'b0;
      assign s_rvalid  = 1'b0;
      assign s_rdata   = '0;
      assign s_rresp   = RESP_OKAY;
    end
  endgenerate

  assign accept = start && (st_q == T_IDLE);
  assign finish = (st_q == T_RUN) && !seq_busy && drained;

  always_comb begin
    st_d   = st_q;
    done_d = finish;
    if (accept)      st_d = T_RUN;
    else if (finish) st_d = T_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  pw_burst_seq #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .MAX_BURST(MAX_BURST)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(accept), .base(base_sel),
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr), .awlen(m_awlen),
    .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata), .wlast(m_wlast),
    .busy(seq_busy)
  );

  pw_resp_track #(.CNT_W(CNT_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .aw_fire(m_awvalid && m_awready), .b_fire(m_bvalid && m_bready),
    .bresp(m_bresp), .drained(drained), .err(err)
  );

  assign ready     = accept;
  assign idle      = (st_q == T_IDLE);
  assign done      = done_q;
  assign m_bready  = (st_q == T_RUN);
  assign m_awsize  = SIZE_WORD;
  assign m_awburst = BURST_INCR;
  assign m_wstrb   = '1;

  // R2
  take_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !idle);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !m_awvalid && !m_wvalid);
  // R8
  done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle && !m_awvalid && !m_wvalid);
endmodule

// File: tb/pattern_writer_test.sv
`timescale 1ns/1ps
module mem_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_req,
  input  logic        awvalid,
  output logic        awready,
  input  logic [31:0] awaddr,
  input  logic [7:0]  awlen,
  input  logic [2:0]  awsize,
  input  logic [1:0]  awburst,
  input  logic        wvalid,
  output logic        wready,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  input  logic        wlast,
  output logic        bvalid,
  input  logic        bready,
  output logic [1:0]  bresp
);
  logic [31:0] mem [int unsigned];
  int          viol, bursts, bpend, beat;
  int unsigned q_addr[$];
  int          q_len[$];
  bit          err_arm;
  logic [7:0]  lfsr;

  assign awready = lfsr[0] | lfsr[3];
  assign wready  = lfsr[1] | lfsr[5];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'h5A; bvalid <= 1'b0; bresp <= 2'b00;
      viol = 0; bursts = 0; bpend = 0; beat = 0; err_arm = 0;
      q_addr.delete(); q_len.delete();
    end else begin
      bit bv;
      if (err_req) err_arm = 1;
      if (awvalid && awready) begin
        bursts++;
        if (awlen > 8'd15) viol++;
        if ((awaddr % 4096) + (awlen + 1) * 4 > 4096) viol++;
        if (awsize != 3'b010 || awburst != 2'b01) viol++;
        q_addr.push_back(awaddr); q_len.push_back(int'(awlen));
      end
      if (wvalid && wready) begin
        if (q_addr.size() == 0) viol++;
        else begin
          mem[q_addr[0] + 4 * beat] = wdata;
          if (wstrb != 4'hF) viol++;
          if (wlast != (beat == q_len[0])) viol++;
          if (beat == q_len[0]) begin
            beat = 0; bpend++;
            void'(q_addr.pop_front()); void'(q_len.pop_front());
          end else beat++;
        end
      end
      bv = bvalid;
      if (bv && bready) bv = 0;
      if (!bv && bpend > 0) begin
        bv = 1; bpend--;
        bresp <= err_arm ? 2'b10 : 2'b00;
        err_arm = 0;
      end
      bvalid <= bv;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end
endmodule

module pw_rig #(parameter int BASE_SRC = 1, parameter int NUM_WORDS = 20) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_in,
  output logic        ready,
  output logic        idle,
  output logic        done,
  output logic        err
);
  logic        awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [31:0] awaddr, wdata, rdata_nc;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst, bresp, bresp_nc, rresp_nc;
  logic [3:0]  wstrb;
  logic        awr_nc, wr_nc, bv_nc, arr_nc, rv_nc;

  pattern_writer #(.NUM_WORDS(NUM_WORDS), .BASE_SRC(BASE_SRC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .idle(idle),
    .done(done), .err(err), .base_in(base_in),
    .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awlen(awlen),
    .m_awsize(awsize), .m_awburst(awburst), .m_wvalid(wvalid), .m_wready(wready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_bvalid(bvalid),
    .m_bready(bready), .m_bresp(bresp),
    .s_awvalid(1'b0), .s_awready(awr_nc), .s_wvalid(1'b0), .s_wready(wr_nc),
    .s_wdata(32'h0), .s_wstrb(4'h0), .s_bvalid(bv_nc), .s_bready(1'b1),
    .s_bresp(bresp_nc), .s_arvalid(1'b0), .s_arready(arr_nc), .s_rvalid(rv_nc),
    .s_rready(1'b1), .s_rdata(rdata_nc), .s_rresp(rresp_nc)
  );

  mem_slave slv (
    .clk(clk), .rst_n(rst_n), .err_req(1'b0),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid),
    .bready(bready), .bresp(bresp)
  );
endmodule

module pattern_writer_test;
  localparam int NW = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, ready, idle, done, err, err_req;
  logic        awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [31:0] awaddr, wdata, base_in;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst, bresp;
  logic [3:0]  wstrb;
  logic        s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid;
  logic        s_arvalid, s_arready, s_rvalid;
  logic [31:0] s_wdata, s_rdata;
  logic [3:0]  s_wstrb;
  logic [1:0]  s_bresp, s_rresp;
  logic        d_start, d_ready, d_idle, d_done, d_err;
  logic        z_start, z_ready, z_idle, z_done, z_err;
  logic [31:0] d_base, z_base;

  int n_chk = 0, n_bad = 0;
  bit busy_m = 0;

  pattern_writer #(.NUM_WORDS(NW), .BASE_SRC(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .idle(idle),
    .done(done), .err(err), .base_in(base_in),
    .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awlen(awlen),
    .m_awsize(awsize), .m_awburst(awburst), .m_wvalid(wvalid), .m_wready(wready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_bvalid(bvalid),
    .m_bready(bready), .m_bresp(bresp),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_wvalid(s_wvalid),
    .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_bvalid(s_bvalid),
    .s_bready(1'b1), .s_bresp(s_bresp), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rready(1'b1), .s_rdata(s_rdata), .s_rresp(s_rresp)
  );

  mem_slave slv0 (
    .clk(clk), .rst_n(rst_n), .err_req(err_req),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid),
    .bready(bready), .bresp(bresp)
  );

  pw_rig #(.BASE_SRC(1), .NUM_WORDS(20)) rig_dir (
    .clk(clk), .rst_n(rst_n), .start(d_start), .base_in(d_base),
    .ready(d_ready), .idle(d_idle), .done(d_done), .err(d_err));
  pw_rig #(.BASE_SRC(0), .NUM_WORDS(20)) rig_zero (
    .clk(clk), .rst_n(rst_n), .start(z_start), .base_in(z_base),
    .ready(z_ready), .idle(z_idle), .done(z_done), .err(z_err));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint rd0(input int unsigned a);
    return slv0.mem.exists(a) ? longint'(slv0.mem[a]) : 64'hDEAD;
  endfunction

  // per-clock reference of idle/done for uut, built from ready and done only
  always @(negedge clk) if (rst_n) begin
    if (done) begin
      check(slv0.bpend == 0 && slv0.q_addr.size() == 0 && !bvalid,
            "R8 done before all responses", slv0.bpend, 0);
      busy_m = 0;
    end
    check(idle == !busy_m, "R8 idle model", idle, !busy_m);
    if (ready) busy_m = 1;
  end

  task automatic lite_write(input logic [31:0] v, input logic [3:0] strb);
    @(negedge clk);
    s_awvalid = 1; s_wvalid = 1; s_wdata = v; s_wstrb = strb;
    #0.5;
    while (!s_awready) @(negedge clk);
    @(posedge clk); #1;
    s_awvalid = 0; s_wvalid = 0;
  endtask

  task automatic lite_read(output logic [31:0] v);
    @(negedge clk);
    s_arvalid = 1;
    #0.5;
    while (!s_arready) @(negedge clk);
    @(posedge clk); #1;
    s_arvalid = 0;
    @(negedge clk);
    v = s_rdata;
  endtask

  task automatic launch(input bit hold);
    @(negedge clk);
    start = 1;
    #0.5;
    while (!ready) @(negedge clk);
    @(posedge clk); #1;
    if (!hold) start = 0;
  endtask

  task automatic check_block(input int unsigned base, input int n, input string tag);
    for (int k = 0; k < n; k++)
      check(rd0(base + 4 * k) == k, tag, rd0(base + 4 * k), k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 run never finished actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int b0;
    rst_n = 0; start = 0; err_req = 0; base_in = 32'h7000;
    s_awvalid = 0; s_wvalid = 0; s_wdata = 0; s_wstrb = 0; s_arvalid = 0;
    d_start = 0; z_start = 0; d_base = 32'h2000; z_base = 32'h3000;
    repeat (2) @(negedge clk);
    // R1 state while reset held
    check(idle && !done && !ready && !awvalid && !wvalid, "R1 reset outputs",
          {idle, done, ready, awvalid, wvalid}, 5'b10000);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    check(idle && !done && !awvalid && !wvalid && !err, "R1 after release",
          {idle, done, awvalid, wvalid, err}, 5'b10000);

    // R7 register offset, byte strobes, read-back
    lite_write(32'hFFFF_FFFF, 4'hF);
    lite_write(32'h0000_0FF0, 4'h3);
    lite_write(32'h0000_0000, 4'hC);
    lite_read(rv);
    check(rv == 32'h0000_0FF0, "R7 register read-back", rv, 32'h0FF0);

    // R3 R4 main run across a 4 KB page
    launch(0);
    do @(negedge clk); while (!done);
    check_block(32'h0FF0, NW, "R3 word value at base+4k");
    check(slv0.bursts == 4, "R4 burst split at page", slv0.bursts, 4);
    check(slv0.viol == 0, "R4 protocol violations in slave", slv0.viol, 0);
    check(!err, "R10 no error on OKAY", err, 0);
    @(negedge clk);
    check(!done, "R8 done is one cycle", done, 0);

    // R10 error response is sticky
    @(negedge clk) err_req = 1;
    @(negedge clk) err_req = 0;
    launch(0);
    do @(negedge clk); while (!done);
    check(err, "R10 error flag after SLVERR", err, 1);
    repeat (4) @(negedge clk);
    check(err, "R10 error flag stays set", err, 1);

    // R9 automatic re-run while start held; R10 clear on acceptance
    slv0.mem.delete();
    b0 = slv0.bursts;
    launch(1);
    @(negedge clk);
    check(!err, "R10 error cleared on accept", err, 0);
    do @(negedge clk); while (!done);
    check(ready, "R9 ready with done while start held", ready, 1);
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    check(!idle, "R9 second run active", idle, 0);
    do @(negedge clk); while (!done);
    check(slv0.bursts - b0 == 8, "R9 two runs of bursts", slv0.bursts - b0, 8);
    check_block(32'h0FF0, NW, "R9 pattern after re-run");
    repeat (5) @(negedge clk);
    check(idle && !ready, "R2 no run without start", {idle, ready}, 2'b10);

    // R6 direct port sampled at acceptance
    @(negedge clk) d_start = 1;
    #0.5;
    while (!d_ready) @(negedge clk);
    @(posedge clk); #1 d_start = 0; d_base = 32'h5000;
    do @(negedge clk); while (!d_done);
    for (int k = 0; k < 20; k++)
      check(rig_dir.slv.mem.exists(32'h2000 + 4 * k) &&
            rig_dir.slv.mem[32'h2000 + 4 * k] == k, "R6 direct base words", k, k);
    check(!rig_dir.slv.mem.exists(32'h5000), "R6 late base change ignored", 1, 0);
    @(negedge clk) d_start = 1;
    #0.5;
    while (!d_ready) @(negedge clk);
    @(posedge clk); #1 d_start = 0;
    do @(negedge clk); while (!d_done);
    check(rig_dir.slv.mem.exists(32'h5000 + 76) &&
          rig_dir.slv.mem[32'h5000 + 76] == 19, "R6 new base on next run", 0, 19);

    // R5 zero source ignores the direct input
    @(negedge clk) z_start = 1;
    #0.5;
    while (!z_ready) @(negedge clk);
    @(posedge clk); #1 z_start = 0;
    do @(negedge clk); while (!z_done);
    for (int k = 0; k < 20; k++)
      check(rig_zero.slv.mem.exists(4 * k) && rig_zero.slv.mem[4 * k] == k,
            "R5 zero base words", k, k);
    check(!rig_zero.slv.mem.exists(32'h3000), "R5 direct input ignored", 1, 0);
    check(rig_dir.slv.viol == 0 && rig_zero.slv.viol == 0, "R11 R4 slave protocol",
          rig_dir.slv.viol + rig_zero.slv.viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule